// File: doc/BRIEF.md
# Signed/Unsigned Integer ALU

This is a purely combinational 32-bit integer arithmetic and logic unit for a simple load/store processor datapath. It takes two operands, a 3-bit operation code and a signed/unsigned select, and it returns a result word, a zero flag and an overflow-trap request. Addition, subtraction and both kinds of less-than compare all run through one shared adder. Subtraction feeds the adder the bitwise inverse of the second operand with a carry-in of one.

The second operand can come either from the register operand or from a 16-bit immediate. The immediate is always sign-extended, whether the operation is signed or unsigned, so the arithmetic core only ever sees full-width operands. The zero flag is the all-zero detect of the adder output, which makes it the equality test whenever the adder is subtracting.

Top module: `int_alu`

## Requirements
- R1: Code 000 gives the bitwise AND of the two operands, and code 001 gives the bitwise OR.
- R2: Code 010 gives (A + B) mod 2^32. The result bits are the same whether `is_unsigned` is 0 or 1.
- R3: Code 110 gives (A - B) mod 2^32, computed as A + ~B + 1. The result bits are the same for either value of `is_unsigned`.
- R4: `ovf_trap` is 1 only when all three of these hold: `is_unsigned` is 0, the code is 010 or 110, and the adder operands (B already inverted for 110) share a sign that differs from the sign of the sum. It is 0 in every other case, and it is always 0 when `is_unsigned` is 1.
- R5: Code 111 with `is_unsigned` = 0 puts the signed comparison A < B in bit 0 of the result. This bit is correct even when A - B overflows: 0x80000000 < 1 gives 1, and 0x7FFFFFFF < 0x80000000 gives 0.
- R6: Code 111 with `is_unsigned` = 1 puts the unsigned comparison A < B in bit 0, so 0xFFFFFFFF is greater than 0. For either kind of compare, bits 31..1 of the result are 0 and the compare never raises `ovf_trap`.
- R7: `zero_flag` is 1 exactly when the adder output is all zero. The adder subtracts for codes 110 and 111 and adds for every other code, so for 110 and 111 the flag means A equals B.
- R8: When `use_imm` is 1, the second operand is `imm16` sign-extended to 32 bits, for every code and for both signed and unsigned forms. In that case `opnd_b` has no effect on any output.
- R9: The undefined codes 011, 100 and 101 give a result of 0 and never raise `ovf_trap`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand from the register path |
| imm16 | input | 16 | Immediate, sign-extended when selected |
| use_imm | input | 1 | 1 selects the extended immediate as the second operand |
| op_sel | input | 3 | Operation code: 000 AND, 001 OR, 010 add, 110 subtract, 111 less-than |
| is_unsigned | input | 1 | 1 selects the unsigned form: no trap, unsigned compare |
| result | output | 32 | Operation result |
| zero_flag | output | 1 | Adder output is all zero |
| ovf_trap | output | 1 | Signed overflow trap request |

## Verification
The bench builds two copies of the block with WIDTH = 32 and IMM_W = 16. One copy uses the cell-level ripple adder (RIPPLE = 1) and the other uses the behavioural adder (RIPPLE = 0), and both copies are checked against the same expectations. At 32 bits, the corner words 0x7FFFFFFF, 0x80000000, 0 and 0xFFFFFFFF sit exactly on the signed overflow and unsigned wrap boundaries. At IMM_W = 16, an immediate of 0x8000 or 0xFFFF exercises the sign fill across the upper half of the word.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [2:0] {
    OP_AND = 3'b000,
    OP_OR  = 3'b001,
    OP_ADD = 3'b010,
    OP_SUB = 3'b110,
    OP_SLT = 3'b111
  } alu_op_e;

  // adder runs in subtract mode for SUB and SLT
  function automatic logic fn_sub_mode(input logic [2:0] op);
    return (op == OP_SUB) || (op == OP_SLT);
  endfunction

  // operations that may raise a signed overflow trap
  function automatic logic fn_may_trap(input logic [2:0] op);
    return (op == OP_ADD) || (op == OP_SUB);
  endfunction

  function automatic logic fn_defined(input logic [2:0] op);
    return (op == OP_AND) || (op == OP_OR) || (op == OP_ADD) ||
           (op == OP_SUB) || (op == OP_SLT);
  endfunction

  // two's-complement overflow from the three sign bits
  function automatic logic fn_sign_ovf(input logic sa, input logic sb, input logic ss);
    return (sa == sb) && (ss != sa);
  endfunction

  // signed less-than corrected for overflow
  function automatic logic fn_slt_signed(input logic sum_msb, input logic ovf);
    return sum_msb ^ ovf;
  endfunction

  // unsigned less-than from the carry of A + ~B + 1
  function automatic logic fn_slt_unsigned(input logic carry_out);
    return ~carry_out;
  endfunction

endpackage

// File: rtl/alu_imm_ext.sv
module alu_imm_ext #(
  parameter int IN_W  = 16,
  parameter int OUT_W = 32
) (
  input  logic [IN_W-1:0]  imm_in,
  output logic [OUT_W-1:0] imm_out
);
  localparam int FILL_W = OUT_W - IN_W;

  assign imm_out = {{FILL_W{imm_in[IN_W-1]}}, imm_in};
endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int W      = 32,
  parameter bit RIPPLE = 1'b1
) (
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         sub_en,
  output logic [W-1:0] sum_out,
  output logic         carry_out,
  output logic         sign_ovf
);
  import alu_pkg::*;

  logic [W-1:0] b_eff;

  assign b_eff = sub_en ? ~b_in : b_in;

  generate
    if (RIPPLE) begin : g_ripple
      logic [W:0] cy;
      assign cy[0] = sub_en;
      for (genvar i = 0; i < W; i++) begin : g_cell
        assign sum_out[i] = a_in[i] ^ b_eff[i] ^ cy[i];
        assign cy[i+1]    = (a_in[i] & b_eff[i]) | (a_in[i] & cy[i]) | (b_eff[i] & cy[i]);
      end
      assign carry_out = cy[W];
    end else begin : g_behav
      logic [W:0] wide;
      assign wide      = {1'b0, a_in} + {1'b0, b_eff} + {{W{1'b0}}, sub_en};
      assign sum_out   = wide[W-1:0];
      assign carry_out = wide[W];
    end
  endgenerate

  assign sign_ovf = fn_sign_ovf(a_in[W-1], b_eff[W-1], sum_out[W-1]);
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] and_out,
  output logic [W-1:0] or_out
);
  assign and_out = a_in & b_in;
  assign or_out  = a_in | b_in;
endmodule

// File: rtl/int_alu.sv
module int_alu #(
  parameter int WIDTH  = 32,
  parameter int IMM_W  = 16,
  parameter bit RIPPLE = 1'b1
) (
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic [IMM_W-1:0] imm16,
  input  logic             use_imm,
  input  logic [2:0]       op_sel,
  input  logic             is_unsigned,
  output logic [WIDTH-1:0] result,
  output logic             zero_flag,
  output logic             ovf_trap
);
  import alu_pkg::*;

  localparam int HI_W = WIDTH - 1;

  // named internal events
  logic [WIDTH-1:0] imm_ext;
  logic [WIDTH-1:0] b_sel;
  logic             sub_en;
  logic [WIDTH-1:0] add_sum;
  logic             add_cout;
  logic             add_ovf;
  logic [WIDTH-1:0] and_v;
  logic [WIDTH-1:0] or_v;
  logic             less_bit;

  alu_imm_ext #(.IN_W(IMM_W), .OUT_W(WIDTH)) u_ext (
    .imm_in (imm16),
    .imm_out(imm_ext)
  );

  assign b_sel  = use_imm ? imm_ext : opnd_b;
  assign sub_en = fn_sub_mode(op_sel);

  alu_adder #(.W(WIDTH), .RIPPLE(RIPPLE)) u_add (
    .a_in     (opnd_a),
    .b_in     (b_sel),
    .sub_en   (sub_en),
    .sum_out  (add_sum),
    .carry_out(add_cout),
    .sign_ovf (add_ovf)
  );

  alu_logic #(.W(WIDTH)) u_logic (
    .a_in   (opnd_a),
    .b_in   (b_sel),
    .and_out(and_v),
    .or_out (or_v)
  );

  assign less_bit = is_unsigned ? fn_slt_unsigned(add_cout)
                                : fn_slt_signed(add_sum[WIDTH-1], add_ovf);

  always_comb begin
    case (op_sel)
      OP_AND:  result = and_v;
      OP_OR:   result = or_v;
      OP_ADD:  result = add_sum;
      OP_SUB:  result = add_sum;
      OP_SLT:  result = {{HI_W{1'b0}}, less_bit};
      default: result = '0;
    endcase
  end

  assign zero_flag = ~|add_sum;
  assign ovf_trap  = ~is_unsigned & fn_may_trap(op_sel) & add_ovf;

  // checks next to the output logic
  always_comb begin
    if (is_unsigned) begin
      AST_UNSIGNED_NO_TRAP: assert (!ovf_trap); // R4
    end
    if (op_sel == OP_SLT) begin
      AST_SLT_HIGH_CLEAR: assert (result[WIDTH-1:1] == '0); // R6
      AST_SLT_NO_TRAP: assert (!ovf_trap); // R6
    end
    if (sub_en) begin
      AST_ZERO_IS_EQUAL: assert (zero_flag == (opnd_a == b_sel)); // R7
    end
    if (!fn_defined(op_sel)) begin
      AST_UNDEF_ZERO: assert (result == '0 && !ovf_trap); // R9
    end
    if (op_sel == OP_ADD && !is_unsigned && opnd_a[WIDTH-1] != b_sel[WIDTH-1]) begin
      AST_MIXED_SIGN_NO_TRAP: assert (!ovf_trap); // R4
    end
  end
endmodule

// File: tb/int_alu_tb_top.sv
module int_alu_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] a, b;
  logic [15:0] imm;
  logic        use_imm, uns;
  logic [2:0]  op;
  logic [31:0] res_r, res_b;
  logic        z_r, z_b, t_r, t_b;
  int          n_run = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  int_alu #(.WIDTH(32), .IMM_W(16), .RIPPLE(1'b1)) dut_i (
    .opnd_a(a), .opnd_b(b), .imm16(imm), .use_imm(use_imm), .op_sel(op),
    .is_unsigned(uns), .result(res_r), .zero_flag(z_r), .ovf_trap(t_r)
  );

  int_alu #(.WIDTH(32), .IMM_W(16), .RIPPLE(1'b0)) dut_beh_i (
    .opnd_a(a), .opnd_b(b), .imm16(imm), .use_imm(use_imm), .op_sel(op),
    .is_unsigned(uns), .result(res_b), .zero_flag(z_b), .ovf_trap(t_b)
  );

  // vector: {op, uns, a, b, result, zero, trap}
  localparam int NV = 16;
  localparam logic [101:0] VEC [NV] = '{
    {3'b000, 1'b0, 32'hFFFF0000, 32'h0F0F0F0F, 32'h0F0F0000, 1'b0, 1'b0}, // R1
    {3'b001, 1'b0, 32'h00FF0000, 32'h0000FF00, 32'h00FFFF00, 1'b0, 1'b0}, // R1
    {3'b010, 1'b0, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 1'b0, 1'b1}, // R2 R4
    {3'b010, 1'b1, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 1'b0, 1'b0}, // R2 R4
    {3'b010, 1'b0, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 1'b1, 1'b0}, // R2 R7
    {3'b110, 1'b0, 32'h80000000, 32'h00000001, 32'h7FFFFFFF, 1'b0, 1'b1}, // R3 R4
    {3'b110, 1'b1, 32'h80000000, 32'h00000001, 32'h7FFFFFFF, 1'b0, 1'b0}, // R3 R4
    {3'b110, 1'b0, 32'h00000005, 32'h00000005, 32'h00000000, 1'b1, 1'b0}, // R3 R7
    {3'b111, 1'b0, 32'h80000000, 32'h00000001, 32'h00000001, 1'b0, 1'b0}, // R5
    {3'b111, 1'b1, 32'h80000000, 32'h00000001, 32'h00000000, 1'b0, 1'b0}, // R6
    {3'b111, 1'b0, 32'hFFFFFFFF, 32'h00000000, 32'h00000001, 1'b0, 1'b0}, // R5
    {3'b111, 1'b1, 32'hFFFFFFFF, 32'h00000000, 32'h00000000, 1'b0, 1'b0}, // R6
    {3'b111, 1'b1, 32'h00000000, 32'hFFFFFFFF, 32'h00000001, 1'b0, 1'b0}, // R6
    {3'b111, 1'b0, 32'h7FFFFFFF, 32'h80000000, 32'h00000000, 1'b0, 1'b0}, // R5
    {3'b011, 1'b0, 32'h12345678, 32'h00000001, 32'h00000000, 1'b0, 1'b0}, // R9
    {3'b100, 1'b0, 32'h7FFFFFFF, 32'h00000001, 32'h00000000, 1'b0, 1'b0}  // R9
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag, input logic [31:0] er, input logic ez, input logic et);
    chk({tag, " result ripple"}, res_r, er);
    chk({tag, " result behav"},  res_b, er);
    chk({tag, " zero ripple"},   {31'd0, z_r}, {31'd0, ez});
    chk({tag, " zero behav"},    {31'd0, z_b}, {31'd0, ez});
    chk({tag, " trap ripple"},   {31'd0, t_r}, {31'd0, et});
    chk({tag, " trap behav"},    {31'd0, t_b}, {31'd0, et});
  endtask

  task automatic apply(input logic [2:0] o, input logic u, input logic ui,
                       input logic [31:0] va, input logic [31:0] vb, input logic [15:0] vi);
    @(negedge clk);
    op = o; uns = u; use_imm = ui; a = va; b = vb; imm = vi;
    #2;
  endtask

  // independent reference built on wide signed arithmetic
  task automatic ref_model(input logic [2:0] o, input logic u, input logic ui,
                           input logic [31:0] va, input logic [31:0] vb, input logic [15:0] vi,
                           output logic [31:0] er, output logic ez, output logic et);
    logic [31:0] ob;
    longint sa, sb, ssum, sdif;
    ob   = ui ? {{16{vi[15]}}, vi} : vb;
    sa   = longint'($signed(va));
    sb   = longint'($signed(ob));
    ssum = sa + sb;
    sdif = sa - sb;
    er = 32'd0;
    et = 1'b0;
    case (o)
      3'b000: er = va & ob;
      3'b001: er = va | ob;
      3'b010: begin
        er = va + ob;
        et = !u && (ssum > 64'sd2147483647 || ssum < -64'sd2147483648);
      end
      3'b110: begin
        er = va - ob;
        et = !u && (sdif > 64'sd2147483647 || sdif < -64'sd2147483648);
      end
      3'b111: er = u ? {31'd0, va < ob} : {31'd0, sa < sb};
      default: er = 32'd0;
    endcase
    ez = (o == 3'b110 || o == 3'b111) ? (va == ob) : ((va + ob) == 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] er;
    logic        ez, et;
    op = 3'b000; uns = 1'b0; use_imm = 1'b0; a = '0; b = '0; imm = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // reset state: all-zero inputs give AND of zeros, adder sum zero
    apply(3'b000, 1'b0, 1'b0, 32'd0, 32'd0, 16'd0);
    check_all("reset R1 R7", 32'd0, 1'b1, 1'b0);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][101:99], VEC[i][98], 1'b0, VEC[i][97:66], VEC[i][65:34], 16'h0);
      check_all($sformatf("vec%0d R1 R2 R3 R4 R5 R6 R7 R9", i),
                VEC[i][33:2], VEC[i][1], VEC[i][0]);
    end

    // R8: immediate sign extension, B ignored
    apply(3'b010, 1'b1, 1'b1, 32'd5, 32'hDEADBEEF, 16'hFFFF);
    check_all("R8 addiu -1", 32'd4, 1'b0, 1'b0);
    apply(3'b111, 1'b1, 1'b1, 32'd5, 32'h0, 16'hFFFF);
    check_all("R8 sltiu vs all-ones", 32'd1, 1'b0, 1'b0);
    apply(3'b111, 1'b0, 1'b1, 32'd0, 32'hFFFFFFFF, 16'h8000);
    check_all("R8 slti vs 0xFFFF8000", 32'd0, 1'b0, 1'b0);
    apply(3'b010, 1'b0, 1'b1, 32'h80000000, 32'h7FFFFFFF, 16'h8000);
    check_all("R8 R4 addi trap", 32'h7FFF8000, 1'b0, 1'b1);
    apply(3'b110, 1'b0, 1'b1, 32'h00001234, 32'h0, 16'h1234);
    check_all("R8 R7 equal immediate", 32'd0, 1'b1, 1'b0);

    // R9: remaining undefined code
    apply(3'b101, 1'b0, 1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'h0);
    check_all("R9 code 101", 32'd0, 1'b0, 1'b0);

    // corner and random operands against the reference, all ops
    for (int k = 0; k < 400; k++) begin
      logic [31:0] ra, rb;
      logic [2:0]  ro;
      logic        ru, ri;
      logic [15:0] rim;
      ra  = $urandom;
      rb  = $urandom;
      if (k < 64) begin
        case (k % 4)
          0: ra = 32'h7FFFFFFF;
          1: ra = 32'h80000000;
          2: ra = 32'h00000000;
          default: ra = 32'hFFFFFFFF;
        endcase
        case ((k / 4) % 4)
          0: rb = 32'h7FFFFFFF;
          1: rb = 32'h80000000;
          2: rb = 32'h00000000;
          default: rb = 32'hFFFFFFFF;
        endcase
      end
      ro  = 3'($urandom);
      ru  = 1'($urandom);
      ri  = (k < 64) ? 1'b0 : 1'($urandom);
      rim = 16'($urandom);
      apply(ro, ru, ri, ra, rb, rim);
      ref_model(ro, ru, ri, ra, rb, rim, er, ez, et);
      check_all($sformatf("rand%0d op%0b R2 R3 R4 R5 R6 R7 R8", k, ro), er, ez, et);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule